// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block takes sixteen interrupt request lines and holds each qualified request in a pending register. A line counts as a request only after it has been high on three clock edges in a row. A writable mask register hides chosen lines from the processor but leaves their pending bits alone. The block compares the unmasked pending set against the set of interrupts already being serviced. It raises one interrupt output when some unmasked pending line outranks everything in service.

The processor answers with a three-pulse acknowledge sequence. The first pulse claims the winning request: its in-service bit is set and its pending bit is cleared on the same edge. The second pulse returns the low vector byte and the third returns the high vector byte. An in-service bit is released in one of two ways. In auto mode it clears at the last acknowledge pulse. Otherwise it stays set until software writes an end-of-interrupt command.

Software reaches three write-only locations through a simple write port: the mask, a configuration word, and the end-of-interrupt command.

Top module: `pic_core`

## Requirements
- R1: Reset clears the pending, in-service and mask registers, drives `int_out` low and `vec_valid` low, and sets `vec_out` to zero.
- R2: A line sets its pending bit only when it is sampled high on three consecutive rising edges. A pulse of one or two cycles never sets it.
- R3: A pending bit whose line goes low before the claiming pulse is withdrawn, and `int_out` falls one cycle later.
- R4: Writing address 0 loads the mask, where bit i set hides line i. A masked pending line never raises `int_out`. Clearing its mask bit while the line is still pending raises `int_out`.
- R5: A masked line of higher priority does not stop an unmasked line of lower priority from raising `int_out`.
- R6: Index 0 has the highest priority. `int_out` is high only when the best unmasked pending index is numerically lower than every index set in the in-service register.
- R7: The acknowledge sequence has three pulses. On pulse 1 the winner's in-service bit is set and its pending bit is cleared. The cycle after pulse 2, `vec_valid` is high and `vec_out` = {base[3:0], index[3:0]}. The cycle after pulse 3, `vec_valid` is high and `vec_out` = page[7:0].
- R8: Writing address 1 loads the configuration: bits [3:0] are the base, bit 4 is auto mode and bits [15:8] are the page. With auto mode set, the claimed in-service bit clears on pulse 3.
- R9: Any write to address 2 clears the highest-priority bit that is set in the in-service register.
- R10: If `int_out` is low at pulse 1, the sequence still runs. It returns index 15 in the low byte and sets no in-service bit.
- R11: A claimed line that stays high does not request again until it has gone low and then qualifies anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 16 | Request lines, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 mask, 1 config, 2 end-of-interrupt |
| wr_data | input | 16 | Write data |
| ack_pulse | input | 1 | One-cycle acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector byte on vec_out is valid this cycle |
| vec_out | output | 8 | Vector byte, low byte then high byte |

## Verification
The assertions take for granted that the request lines are already synchronous to `clk`. They also take for granted that each acknowledge pulse lasts exactly one cycle and that a sequence is never cut short. The bench therefore drives every input on the falling edge and issues acknowledge pulses only in complete groups of three. It never writes the end-of-interrupt command in the same cycle as a final acknowledge pulse, so the two clearing paths never meet on one edge.

// File: rtl/pic_pkg.sv
// pic_pkg: shared types and register addresses for the interrupt controller.
// Assumes a two-bit write address space.
package pic_pkg;
    // Write port address map
    localparam logic [1:0] ADDR_MASK = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_EOI  = 2'd2;

    // Position within the three-pulse acknowledge sequence
    typedef enum logic [1:0] {
        ACK_IDLE     = 2'd0,
        ACK_CLAIMED  = 2'd1,
        ACK_LOW_SENT = 2'd2
    } ack_state_e;
endpackage

// File: rtl/pic_qual.sv
// pic_qual: qualifies one request line and holds its pending bit.
// The bit sets once the line has been high on QUAL_CYCLES consecutive edges.
// It clears when the line drops or when the line is claimed.
// Assumes the line is already synchronous to clk.
module pic_qual #(
    parameter int QUAL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic claim,
    output logic pend
);
    localparam int CNT_W = $clog2(QUAL_CYCLES + 1);

    logic [CNT_W-1:0] run_cnt;

    // Count consecutive high samples, set pending once per high period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            pend    <= 1'b0;
        end else if (!line_in) begin
            run_cnt <= '0;
            pend    <= 1'b0;
        end else begin
            if (run_cnt < CNT_W'(QUAL_CYCLES)) begin
                run_cnt <= run_cnt + 1'b1;
            end
            if (run_cnt == CNT_W'(QUAL_CYCLES - 1)) begin
                pend <= 1'b1;
            end
            if (claim) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pic_prio.sv
// pic_prio: finds the lowest set index of a vector (index 0 ranks highest).
// Purely combinational.
module pic_prio #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the bottom rank upward so the highest rank wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_ack_fsm.sv
// pic_ack_fsm: runs the three-pulse acknowledge sequence.
// Pulse 1 claims the winner, or the default index when no request is up.
// Pulse 2 returns {base, index} and pulse 3 returns the page byte.
// Assumes ack pulses last one cycle and sequences always complete.
module pic_ack_fsm
    import pic_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int BASE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic              int_req,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic [BASE_W-1:0] base,
    input  logic [7:0]        page,
    input  logic              auto_eoi,
    output logic              claim_en,
    output logic [IDX_W-1:0]  claim_idx,
    output logic              aeoi_clr,
    output logic [IDX_W-1:0]  aeoi_idx,
    output logic              vec_valid,
    output logic [7:0]        vec_out
);
    ack_state_e       state;
    logic [IDX_W-1:0] idx_q;
    logic             spur_q;

    // Sequence state, latched index and registered vector bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ACK_IDLE;
            idx_q     <= '1;
            spur_q    <= 1'b0;
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= 1'b0;
            if (ack) begin
                unique case (state)
                    ACK_IDLE: begin
                        state  <= ACK_CLAIMED;
                        idx_q  <= int_req ? win_idx : '1;
                        spur_q <= !int_req;
                    end
                    ACK_CLAIMED: begin
                        state     <= ACK_LOW_SENT;
                        vec_out   <= {base, idx_q};
                        vec_valid <= 1'b1;
                    end
                    ACK_LOW_SENT: begin
                        state     <= ACK_IDLE;
                        vec_out   <= page;
                        vec_valid <= 1'b1;
                    end
                    default: state <= ACK_IDLE;
                endcase
            end
        end
    end

    // Claim strobe on pulse 1, auto release strobe on pulse 3
    always_comb begin
        claim_en  = ack && (state == ACK_IDLE) && int_req;
        claim_idx = win_idx;
        aeoi_clr  = ack && (state == ACK_LOW_SENT) && auto_eoi && !spur_q;
        aeoi_idx  = idx_q;
    end
endmodule

// File: rtl/pic_core.sv
// pic_core: top of the priority interrupt controller.
// It holds the pending, mask and in-service registers and raises int_out.
// It drives the acknowledge sequencer and takes register writes.
// Assumes the request lines are synchronous to clk.
module pic_core
    import pic_pkg::*;
#(
    parameter int NUM_IRQ     = 16,
    parameter int QUAL_CYCLES = 3,
    parameter int DATA_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               ack_pulse,
    output logic               int_out,
    output logic               vec_valid,
    output logic [7:0]         vec_out
);
    localparam int IDX_W    = $clog2(NUM_IRQ);
    localparam int BASE_W   = 8 - IDX_W;
    localparam int AEOI_BIT = BASE_W;

    logic [NUM_IRQ-1:0] irr_q;
    logic [NUM_IRQ-1:0] imr_q;
    logic [NUM_IRQ-1:0] isr_q;
    logic [BASE_W-1:0]  base_q;
    logic [7:0]         page_q;
    logic               aeoi_q;

    logic [NUM_IRQ-1:0] req_eff;
    logic               req_found;
    logic [IDX_W-1:0]   req_idx;
    logic               isr_found;
    logic [IDX_W-1:0]   isr_idx;
    logic               claim_en;
    logic [IDX_W-1:0]   claim_idx;
    logic               aeoi_clr;
    logic [IDX_W-1:0]   aeoi_idx;
    logic [NUM_IRQ-1:0] set_vec;
    logic [NUM_IRQ-1:0] clr_auto_vec;
    logic [NUM_IRQ-1:0] clr_eoi_vec;
    logic               eoi_cmd;

    // One qualifier per request line
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        pic_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (irq_lines[g]),
            .claim   (set_vec[g]),
            .pend    (irr_q[g])
        );
    end

    // Mask gates the pending set
    assign req_eff = irr_q & ~imr_q;

    pic_prio #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_req_prio (
        .vec   (req_eff),
        .found (req_found),
        .idx   (req_idx)
    );

    pic_prio #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_isr_prio (
        .vec   (isr_q),
        .found (isr_found),
        .idx   (isr_idx)
    );

    // Request outranks everything in service
    assign int_out = req_found && (!isr_found || (req_idx < isr_idx));

    pic_ack_fsm #(.IDX_W(IDX_W), .BASE_W(BASE_W)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack       (ack_pulse),
        .int_req   (int_out),
        .win_idx   (req_idx),
        .base      (base_q),
        .page      (page_q),
        .auto_eoi  (aeoi_q),
        .claim_en  (claim_en),
        .claim_idx (claim_idx),
        .aeoi_clr  (aeoi_clr),
        .aeoi_idx  (aeoi_idx),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    // Decode set and clear requests for the in-service register
    always_comb begin
        eoi_cmd      = wr_en && (wr_addr == ADDR_EOI);
        set_vec      = claim_en ? (NUM_IRQ'(1) << claim_idx) : '0;
        clr_auto_vec = aeoi_clr ? (NUM_IRQ'(1) << aeoi_idx) : '0;
        clr_eoi_vec  = (eoi_cmd && isr_found) ? (NUM_IRQ'(1) << isr_idx) : '0;
    end

    // In-service register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q | set_vec) & ~clr_auto_vec & ~clr_eoi_vec;
        end
    end

    // Software-writable mask and configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q  <= '0;
            base_q <= '0;
            page_q <= '0;
            aeoi_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_MASK) begin
                imr_q <= wr_data[NUM_IRQ-1:0];
            end
            if (wr_addr == ADDR_CFG) begin
                base_q <= wr_data[BASE_W-1:0];
                aeoi_q <= wr_data[AEOI_BIT];
                page_q <= wr_data[15:8];
            end
        end
    end
endmodule

// File: rtl/pic_core_chk.sv
// pic_core_chk: protocol and ordering checks for pic_core, attached by bind.
// Assumes request lines are synchronous and ack pulses last one cycle.
module pic_core_chk #(
    parameter int NUM_IRQ = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_lines,
    input logic               ack_pulse,
    input logic               int_out,
    input logic               vec_valid,
    input logic [NUM_IRQ-1:0] irr,
    input logic [NUM_IRQ-1:0] imr,
    input logic [NUM_IRQ-1:0] isr
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!int_out && !vec_valid && isr == '0 && irr == '0));

    // R2
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_qual_chk
        qual_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irr[g]) |-> ($past(irq_lines[g]) && $past(irq_lines[g], 2)
                               && $past(irq_lines[g], 3)));
    end

    // R6
    int_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> |(irr & ~imr));

    // R7
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_pulse));

    // R7
    isr_set_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(isr & ~$past(isr))) |-> $past(ack_pulse));

    // R7
    isr_single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr & ~$past(isr)));
endmodule

bind pic_core pic_core_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .ack_pulse (ack_pulse),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .irr       (irr_q),
    .imr       (imr_q),
    .isr       (isr_q)
);

// File: tb/pic_core_tb.sv
module pic_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ack_pulse = 1'b0;
    logic        int_out;
    logic        vec_valid;
    logic [7:0]  vec_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pic_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ack_pulse (ack_pulse),
        .int_out   (int_out),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    // {expected int_out, irq_lines}; mask = 0x0001 while this walks
    localparam logic [16:0] QUAL_TBL [0:16] = '{
        17'h0_0001, 17'h0_0001, 17'h0_0001, 17'h0_0000,
        17'h0_0100, 17'h0_0100, 17'h0_0000, 17'h0_0000,
        17'h0_0100, 17'h0_0100, 17'h1_0100, 17'h0_0000,
        17'h0_0003, 17'h0_0003, 17'h1_0003, 17'h1_0002,
        17'h0_0000
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        ack_pulse = 1'b1;
        @(negedge clk);
        ack_pulse = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        chk("R1 int_out in reset", 16'(int_out), 16'h0);
        chk("R1 vec_valid in reset", 16'(vec_valid), 16'h0);
        chk("R1 vec_out in reset", 16'(vec_out), 16'h0);
        rst_n = 1'b1;
        tick(1);

        // Table walk: R2 qualification, R3 withdrawal, R4/R5 masking
        wr(2'd0, 16'h0001);
        foreach (QUAL_TBL[i]) begin
            irq_lines = QUAL_TBL[i][15:0];
            tick(1);
            chk($sformatf("R2/R3/R4/R5 table step %0d", i), 16'(int_out), 16'(QUAL_TBL[i][16]));
        end

        // Nesting and explicit end-of-interrupt, auto mode off
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h5C0A);
        irq_lines[5] = 1'b1; tick(3);
        chk("R2 line5 qualified", 16'(int_out), 16'h1);
        pulse();
        chk("R7 claim drops int_out", 16'(int_out), 16'h0);
        pulse();
        chk("R7 low byte valid", 16'(vec_valid), 16'h1);
        chk("R7 low byte", 16'(vec_out), 16'h00A5);
        pulse();
        chk("R7 high byte", 16'(vec_out), 16'h005C);
        tick(1);
        chk("R7 vec_valid single cycle", 16'(vec_valid), 16'h0);
        chk("R11 held line5 no rerequest", 16'(int_out), 16'h0);
        irq_lines[7] = 1'b1; tick(3);
        chk("R6 line7 below in-service 5", 16'(int_out), 16'h0);
        irq_lines[3] = 1'b1; tick(3);
        chk("R6 line3 above in-service 5", 16'(int_out), 16'h1);
        pulse(); pulse();
        chk("R7 nested low byte", 16'(vec_out), 16'h00A3);
        pulse();
        chk("R6 line7 blocked by 3 and 5", 16'(int_out), 16'h0);
        wr(2'd2, 16'h0000);
        chk("R9 first eoi clears only 3", 16'(int_out), 16'h0);
        wr(2'd2, 16'h0000);
        chk("R9 second eoi clears 5", 16'(int_out), 16'h1);
        pulse(); pulse();
        chk("R7 line7 low byte", 16'(vec_out), 16'h00A7);
        pulse();
        wr(2'd2, 16'h0000);
        chk("R11 held lines stay quiet", 16'(int_out), 16'h0);
        irq_lines = '0; tick(2);

        // Automatic end-of-interrupt
        wr(2'd1, 16'h5C1A);
        irq_lines[9] = 1'b1; tick(3);
        pulse(); pulse();
        chk("R8 line9 low byte", 16'(vec_out), 16'h00A9);
        pulse();
        irq_lines[12] = 1'b1; tick(3);
        chk("R8 in-service 9 released", 16'(int_out), 16'h1);
        pulse(); pulse(); pulse();
        irq_lines = '0; tick(1);
        irq_lines[13] = 1'b1; tick(3);
        chk("R8 in-service 12 released", 16'(int_out), 16'h1);
        pulse(); pulse(); pulse();
        irq_lines = '0; tick(2);

        // Withdrawn request yields default vector
        wr(2'd1, 16'h5C0A);
        irq_lines[2] = 1'b1; tick(3);
        chk("R2 line2 qualified", 16'(int_out), 16'h1);
        irq_lines[2] = 1'b0; tick(1);
        chk("R3 withdrawn line2", 16'(int_out), 16'h0);
        pulse(); pulse();
        chk("R10 default low byte", 16'(vec_out), 16'h00AF);
        pulse();
        irq_lines[15] = 1'b1; tick(3);
        chk("R10 no in-service bit set", 16'(int_out), 16'h1);
        pulse(); pulse(); pulse();
        wr(2'd2, 16'h0000);
        irq_lines = '0; tick(2);

        // Mask and unmask a pending line, then reset mid-run
        irq_lines[4] = 1'b1; tick(3);
        wr(2'd0, 16'hFFFF);
        chk("R4 masked pending line", 16'(int_out), 16'h0);
        wr(2'd0, 16'hFFEF);
        chk("R4 unmasked pending line", 16'(int_out), 16'h1);
        @(negedge clk);
        rst_n = 1'b0; irq_lines = '0;
        tick(2);
        chk("R1 int_out after reset", 16'(int_out), 16'h0);
        chk("R1 vec_valid after reset", 16'(vec_valid), 16'h0);
        rst_n = 1'b1;
        irq_lines[0] = 1'b1; tick(3);
        chk("R1 mask cleared by reset", 16'(int_out), 16'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule